// File: doc/BRIEF.md
# Four-Channel Hysteretic Signal Detector

This block watches four data channels and decides, for each one, whether a usable signal is present. An upstream converter supplies a digital peak-to-peak amplitude for each channel, in millivolts, together with a valid strobe. The block compares each measurement against two programmable thresholds. An upper "turn-on" level sets the flag. A lower "turn-off" level clears it. Between the two levels the flag keeps its value, which gives a hysteresis band. A flag changes only after four consecutive valid samples agree, so a single spike or dropout has no effect.

The thresholds are chosen per channel by 2-bit codes held in two configuration bytes, written through a simple register write port. The four flags leave the block on one output per channel and also as the low nibble of a read-only status byte. A per-channel enable is also produced. It can come from the enable pins, from register enable bits, or, while the enable source is the pins, from the channel's own detect flag. In that last case a channel with no signal drops into standby by itself. Detection keeps running whatever the enable state is.

Top module: `sigdet_quad`

## Requirements
- R1: A channel's flag goes from 0 to 1 on the clock edge that captures the fourth consecutive valid sample whose amplitude is strictly greater than that channel's turn-on level.
- R2: A channel's flag goes from 1 to 0 on the clock edge that captures the fourth consecutive valid sample whose amplitude is strictly less than that channel's turn-off level.
- R3: A sample between the levels, or equal to the level being tested, leaves the flag unchanged. With the flag at 0 only the turn-on level is tested; with the flag at 1 only the turn-off level is tested.
- R4: A valid sample that does not meet the pending condition restarts the count of four. Cycles with the strobe low neither advance nor restart the count.
- R5: Turn-on codes, taken from channel n's bits 2n+1:2n of the byte at address 0x05, map 00 to 70 mV, 01 to 55 mV, 10 to 90 mV and 11 to 75 mV. After reset every code is 00.
- R6: Turn-off codes, taken from channel n's bits 2n+1:2n of the byte at address 0x06, map 00 to 40 mV, 01 to 30 mV, 10 to 55 mV and 11 to 45 mV. After reset every code is 00.
- R7: A new threshold code applies to the first sample captured after the write edge. Writing a code does not change the flag.
- R8: The status byte carries channel n's flag in bit n (channel 3 in bit 3, channel 0 in bit 0), and bits 7:4 read 0.
- R9: When bit 0 of the byte at address 0x07 is 1, each channel's enable equals its register enable bit. When that bit is 0 and auto-enable is high, the enable equals the channel's own flag. Otherwise the enable equals the channel's enable pin.
- R10: Detection keeps updating the flag while the channel's enable is low.
- R11: After reset every flag is 0, the status byte is 0x00 and the control bit at address 0x07 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| amp_valid | input | 4 | Per-channel sample strobe |
| amp_mv | input | 40 | Per-channel amplitude in mV, channel n in bits 10n+9:10n |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| en_pin | input | 4 | Per-channel enable pins |
| auto_en | input | 1 | Select flag-to-enable loopback when the pins are the enable source |
| ch_en_reg | input | 4 | Per-channel register enable bits, active high |
| sd_flag | output | 4 | Per-channel signal-detect flags |
| sd_status | output | 8 | Status byte: flags in bits 3:0, zero above |
| ch_enable | output | 4 | Per-channel enable, 1 = active, 0 = standby |

## Verification
A flag is registered, so it changes on the edge that captures the fourth qualifying sample and can be seen just after that edge. The status byte and the enables are combinational from the flags, the control bit and the pins, so they follow in the same cycle. A configuration write lands on its edge and governs the next captured sample. The bench drives every input shortly after a rising edge and checks each result one nanosecond after the edge that should produce it. It checks the cycle before that edge as well, so a flag that moves one sample early or late is caught.

// File: rtl/sigdet_pkg.sv
// sigdet_pkg: shared constants and threshold-code tables for the signal detector.
// Assumes threshold values fit in 8 bits (all table entries are below 256 mV).
package sigdet_pkg;

    localparam logic [7:0] ADDR_ON_CODES  = 8'h05;
    localparam logic [7:0] ADDR_OFF_CODES = 8'h06;
    localparam logic [7:0] ADDR_EN_CTRL   = 8'h07;

    typedef logic [1:0] thr_code_t;

    // Turn-on level in mV for a 2-bit code (table is deliberately not monotonic).
    function automatic logic [7:0] on_code_mv(input thr_code_t code);
        case (code)
            2'b00:   on_code_mv = 8'd70;
            2'b01:   on_code_mv = 8'd55;
            2'b10:   on_code_mv = 8'd90;
            default: on_code_mv = 8'd75;
        endcase
    endfunction

    // Turn-off level in mV for a 2-bit code.
    function automatic logic [7:0] off_code_mv(input thr_code_t code);
        case (code)
            2'b00:   off_code_mv = 8'd40;
            2'b01:   off_code_mv = 8'd30;
            2'b10:   off_code_mv = 8'd55;
            default: off_code_mv = 8'd45;
        endcase
    endfunction

endpackage

// File: rtl/sigdet_cfg_regs.sv
// sigdet_cfg_regs: holds the turn-on code byte, the turn-off code byte and the
// enable-source control bit. Writes land on the clock edge with cfg_we high.
// Assumes 2*NUM_CH <= 8 so that all codes fit in one byte.
module sigdet_cfg_regs
    import sigdet_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [7:0]            cfg_addr,
    input  logic [7:0]            cfg_wdata,
    output logic [2*NUM_CH-1:0]   on_codes,
    output logic [2*NUM_CH-1:0]   off_codes,
    output logic                  en_src_reg
);

    localparam int CODE_W = 2 * NUM_CH;

    // Register the three configuration bytes; reset to all-zero codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_codes   <= '0;
            off_codes  <= '0;
            en_src_reg <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_addr == ADDR_ON_CODES)  on_codes   <= cfg_wdata[CODE_W-1:0];
            if (cfg_addr == ADDR_OFF_CODES) off_codes  <= cfg_wdata[CODE_W-1:0];
            if (cfg_addr == ADDR_EN_CTRL)   en_src_reg <= cfg_wdata[0];
        end
    end

    p_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_ON_CODES) |=> (on_codes == $past(cfg_wdata[CODE_W-1:0])));

    p_off_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_OFF_CODES) |=> (off_codes == $past(cfg_wdata[CODE_W-1:0])));

    p_codes_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(on_codes) && $stable(off_codes) && $stable(en_src_reg)));

endmodule

// File: rtl/sigdet_thresh_dec.sv
// sigdet_thresh_dec: turns one channel's 2-bit turn-on and turn-off codes
// into millivolt levels at the amplitude width. Purely combinational.
// Assumes AMP_W >= 8.
module sigdet_thresh_dec
    import sigdet_pkg::*;
#(
    parameter int AMP_W = 10
) (
    input  thr_code_t          on_code,
    input  thr_code_t          off_code,
    output logic [AMP_W-1:0]   on_mv,
    output logic [AMP_W-1:0]   off_mv
);

    // Table lookup, widened to the amplitude width.
    always_comb begin
        on_mv  = AMP_W'(on_code_mv(on_code));
        off_mv = AMP_W'(off_code_mv(off_code));
    end

endmodule

// File: rtl/sigdet_chan.sv
// sigdet_chan: hysteretic detect flag for one channel with a dwell filter.
// While the flag is 0 it waits for samples strictly above the turn-on level;
// while it is 1 it waits for samples strictly below the turn-off level.
// The flag toggles once DWELL consecutive valid samples meet that condition.
// Invalid cycles are ignored. A valid sample that misses the condition clears the run.
module sigdet_chan #(
    parameter int AMP_W = 10,
    parameter int DWELL = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               amp_valid,
    input  logic [AMP_W-1:0]   amp_mv,
    input  logic [AMP_W-1:0]   on_mv,
    input  logic [AMP_W-1:0]   off_mv,
    output logic               sd
);

    localparam int CNT_W = $clog2(DWELL + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL - 1);

    logic [CNT_W-1:0] run_cnt;
    logic             toward;

    // Condition that would move the flag away from its present value.
    always_comb toward = sd ? (amp_mv < off_mv) : (amp_mv > on_mv);

    // Count qualifying samples and toggle the flag at the end of the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd      <= 1'b0;
            run_cnt <= '0;
        end else if (amp_valid) begin
            if (!toward) begin
                run_cnt <= '0;
            end else if (run_cnt == LAST) begin
                sd      <= ~sd;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    p_rise_above_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd) |-> $past(amp_valid && (amp_mv > on_mv)));

    p_fall_below_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd) |-> $past(amp_valid && (amp_mv < off_mv)));

    p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !amp_valid |=> ($stable(sd) && $stable(run_cnt)));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= LAST);

endmodule

// File: rtl/sigdet_quad.sv
// sigdet_quad: top of the multi-channel signal detector. It instantiates the
// configuration registers and, per channel, a code decoder and a hysteretic
// detector. It builds the status byte and selects each channel's enable source.
// Assumes NUM_CH <= 4 so that the flags and codes fit in single bytes.
module sigdet_quad
    import sigdet_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int AMP_W  = 10,
    parameter int DWELL  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        amp_valid,
    input  logic [NUM_CH*AMP_W-1:0]  amp_mv,
    input  logic                     cfg_we,
    input  logic [7:0]               cfg_addr,
    input  logic [7:0]               cfg_wdata,
    input  logic [NUM_CH-1:0]        en_pin,
    input  logic                     auto_en,
    input  logic [NUM_CH-1:0]        ch_en_reg,
    output logic [NUM_CH-1:0]        sd_flag,
    output logic [7:0]               sd_status,
    output logic [NUM_CH-1:0]        ch_enable
);

    localparam int PAD_W = 8 - NUM_CH;

    logic [2*NUM_CH-1:0] on_codes;
    logic [2*NUM_CH-1:0] off_codes;
    logic                en_src_reg;

    sigdet_cfg_regs #(.NUM_CH(NUM_CH)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .on_codes   (on_codes),
        .off_codes  (off_codes),
        .en_src_reg (en_src_reg)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [AMP_W-1:0] on_mv;
        logic [AMP_W-1:0] off_mv;

        sigdet_thresh_dec #(.AMP_W(AMP_W)) u_dec (
            .on_code  (on_codes[2*ch +: 2]),
            .off_code (off_codes[2*ch +: 2]),
            .on_mv    (on_mv),
            .off_mv   (off_mv)
        );

        sigdet_chan #(.AMP_W(AMP_W), .DWELL(DWELL)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .amp_valid (amp_valid[ch]),
            .amp_mv    (amp_mv[ch*AMP_W +: AMP_W]),
            .on_mv     (on_mv),
            .off_mv    (off_mv),
            .sd        (sd_flag[ch])
        );

        // Enable source: register bits, else own flag (auto), else pin.
        always_comb begin
            if (en_src_reg)   ch_enable[ch] = ch_en_reg[ch];
            else if (auto_en) ch_enable[ch] = sd_flag[ch];
            else              ch_enable[ch] = en_pin[ch];
        end

        p_auto_loop_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_src_reg && auto_en && $rose(sd_flag[ch])) |-> ch_enable[ch]);

        p_reg_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
            en_src_reg |-> (ch_enable[ch] == ch_en_reg[ch]));
    end

    // Status byte: flags in the low bits, zero padding above.
    always_comb sd_status = {{PAD_W{1'b0}}, sd_flag};

    p_status_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sd_status[7:NUM_CH] == '0);

endmodule

// File: tb/sigdet_quad_tb.sv
`timescale 1ns/1ps
module sigdet_quad_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  amp_valid = '0;
    logic [39:0] amp_mv = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [3:0]  en_pin = 4'b1111;
    logic        auto_en = 1'b0;
    logic [3:0]  ch_en_reg = '0;
    logic [3:0]  sd_flag;
    logic [7:0]  sd_status;
    logic [3:0]  ch_enable;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sigdet_quad u_dut (
        .clk(clk), .rst_n(rst_n), .amp_valid(amp_valid), .amp_mv(amp_mv),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .en_pin(en_pin), .auto_en(auto_en), .ch_en_reg(ch_en_reg),
        .sd_flag(sd_flag), .sd_status(sd_status), .ch_enable(ch_enable)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; amp_valid = '0; cfg_we = 1'b0; auto_en = 1'b0;
        en_pin = 4'b1111; ch_en_reg = '0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    // n valid samples with the given per-channel amplitudes and strobe mask.
    task automatic samples(input int n, input logic [39:0] amps, input logic [3:0] mask);
        for (int i = 0; i < n; i++) begin
            amp_mv = amps; amp_valid = mask;
            tick();
            amp_valid = '0;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
    endtask

    function automatic logic [39:0] all4(input logic [9:0] v);
        return {v, v, v, v};
    endfunction

    task automatic t_reset();
        do_reset();
        chk("R11 flags after reset", {4'b0, sd_flag}, 8'h00);
        chk("R11 status after reset", sd_status, 8'h00);
        chk("R11 enable follows pins after reset", {4'b0, ch_enable}, 8'h0F);
    endtask

    task automatic t_rise_fall();
        do_reset();
        // ch0 at 71 (above 70), ch1 at exactly 70
        samples(3, {10'd0, 10'd0, 10'd70, 10'd71}, 4'b0011);
        chk("R1 no rise after three samples", {4'b0, sd_flag}, 8'h00);
        samples(1, {10'd0, 10'd0, 10'd70, 10'd71}, 4'b0011);
        chk("R1 rise on fourth sample / R3 equal to on level", {4'b0, sd_flag}, 8'h01);
        samples(6, {30'd0, 10'd50}, 4'b0001);
        chk("R3 inside band holds", {4'b0, sd_flag}, 8'h01);
        samples(4, {30'd0, 10'd40}, 4'b0001);
        chk("R3 equal to off level holds", {4'b0, sd_flag}, 8'h01);
        samples(3, {30'd0, 10'd39}, 4'b0001);
        chk("R2 no fall after three samples", {4'b0, sd_flag}, 8'h01);
        samples(1, {30'd0, 10'd39}, 4'b0001);
        chk("R2 fall on fourth sample", {4'b0, sd_flag}, 8'h00);
    endtask

    task automatic t_run_restart();
        do_reset();
        samples(3, {10'd0, 10'd100, 20'd0}, 4'b0100);
        samples(1, {10'd0, 10'd50, 20'd0}, 4'b0100);
        samples(3, {10'd0, 10'd100, 20'd0}, 4'b0100);
        chk("R4 broken run restarts", {4'b0, sd_flag}, 8'h00);
        samples(1, {10'd0, 10'd100, 20'd0}, 4'b0100);
        chk("R4 fourth after restart", {4'b0, sd_flag}, 8'h04);
        do_reset();
        samples(2, {10'd0, 10'd100, 20'd0}, 4'b0100);
        tick(); tick();
        samples(1, {10'd0, 10'd100, 20'd0}, 4'b0100);
        chk("R4 idle cycles do not count", {4'b0, sd_flag}, 8'h00);
        samples(1, {10'd0, 10'd100, 20'd0}, 4'b0100);
        chk("R4 idle cycles do not break run", {4'b0, sd_flag}, 8'h04);
    endtask

    task automatic t_on_table();
        do_reset();
        // ch0=01(55) ch1=10(90) ch2=11(75) ch3=00(70)
        wr(8'h05, 8'h39);
        samples(4, all4(10'd56), 4'b1111);
        chk("R5 code 01 is 55 mV", sd_status, 8'h01);
        samples(4, all4(10'd76), 4'b1111);
        chk("R5 codes 11 and 00 are 75 and 70 mV / R8", sd_status, 8'h0D);
        samples(4, all4(10'd91), 4'b1111);
        chk("R5 code 10 is 90 mV / R8", sd_status, 8'h0F);
        // ch0=01(30) ch1=10(55) ch2=11(45) ch3=00(40)
        wr(8'h06, 8'h39);
        samples(4, all4(10'd54), 4'b1111);
        chk("R6 code 10 is 55 mV", sd_status, 8'h0D);
        samples(4, all4(10'd44), 4'b1111);
        chk("R6 code 11 is 45 mV", sd_status, 8'h09);
        samples(4, all4(10'd39), 4'b1111);
        chk("R6 code 00 is 40 mV", sd_status, 8'h01);
        samples(4, all4(10'd29), 4'b1111);
        chk("R6 code 01 is 30 mV", sd_status, 8'h00);
    endtask

    task automatic t_code_change();
        do_reset();
        samples(2, {30'd0, 10'd80}, 4'b0001);
        wr(8'h05, 8'h02);
        samples(2, {30'd0, 10'd80}, 4'b0001);
        chk("R7 raised on level applies to next sample", {4'b0, sd_flag}, 8'h00);
        wr(8'h05, 8'h00);
        samples(4, {30'd0, 10'd80}, 4'b0001);
        chk("R7 restored level detects", {4'b0, sd_flag}, 8'h01);
        wr(8'h05, 8'h02);
        chk("R7 write keeps flag", {4'b0, sd_flag}, 8'h01);
        samples(1, {30'd0, 10'd80}, 4'b0001);
        chk("R7 flag kept after next sample", {4'b0, sd_flag}, 8'h01);
    endtask

    task automatic t_enable();
        do_reset();
        en_pin = 4'b0101;
        #1 chk("R9 pins drive enable", {4'b0, ch_enable}, 8'h05);
        auto_en = 1'b1;
        #1 chk("R9 auto follows flags", {4'b0, ch_enable}, 8'h00);
        samples(4, {20'd0, 10'd100, 10'd0}, 4'b0010);
        chk("R9 auto enable on signal", {4'b0, ch_enable}, 8'h02);
        samples(4, {20'd0, 10'd10, 10'd0}, 4'b0010);
        chk("R10 auto standby on loss", {4'b0, ch_enable}, 8'h00);
        ch_en_reg = 4'b1010;
        wr(8'h07, 8'h01);
        chk("R9 register source overrides auto", {4'b0, ch_enable}, 8'h0A);
        samples(4, {30'd0, 10'd100}, 4'b0001);
        chk("R10 detection in standby", {4'b0, sd_flag}, 8'h01);
        chk("R10 standby channel stays off", {4'b0, ch_enable}, 8'h0A);
    endtask

    initial begin
        tick();
        t_reset();
        t_rise_fall();
        t_run_restart();
        t_on_table();
        t_code_change();
        t_enable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule